// File: doc/BRIEF.md
# Interrupt Status Aggregator with Per-Source Acknowledge

This block collects twelve event sources of a serial bus controller into one interrupt line. Each source has a bit in a raw status word. Ten of the sources are sticky: a one-cycle pulse sets the bit, and the bit stays set until software acknowledges it. Two sources are level sources (receive-threshold and transmit-empty). Their bits track the input and cannot be acknowledged. An enable word gates the raw bits into a pending word, and the interrupt output is high whenever any pending bit is set.

Software acknowledges a sticky source by reading that source's own acknowledge address. A read of the acknowledge-all address clears every sticky source at once. An event that arrives after software has read the pending word and before it reads acknowledge-all is then lost, so per-source acknowledge is the safer pattern. A twelve-bit abort-cause word records why a transfer was aborted. The cause word is wiped by the same read that acknowledges the abort source. The register port is a plain single-cycle read/write bus. Read data is combinational in the cycle of the read strobe, and read side effects take place at the clock edge that ends that cycle.

Top module: `irq_aggregator`

## Requirements
- R1: After a synchronous active-low reset, the raw word, the enable word and the cause word are all zero and `irq_o` is low.
- R2: A sticky source (any bit except 2 and 4) is set by a one-cycle pulse on its `src_in` bit. It stays set until an acknowledge read clears it. Bit order: 0 rx-underrun, 1 rx-overrun, 2 rx-threshold, 3 tx-overrun, 4 tx-empty, 5 read-request, 6 tx-abort, 7 rx-done, 8 activity, 9 stop-seen, 10 start-seen, 11 general-call.
- R3: Level sources (bits 2 and 4) show in the raw word the value their input had in the previous cycle. Acknowledge reads have no effect on them.
- R4: Reading address 0 returns raw AND enable. Address 1 returns the raw word. Address 2 is the enable word and is readable and writable.
- R5: `irq_o` is the OR of all pending bits. An enable word of zero keeps `irq_o` low.
- R6: A read of address 5+i acknowledges source i only. It returns 1 in bit 0 if bit i was set before the read, and zero in all other bits.
- R7: A read of address 4 clears every sticky source and the cause word. It returns 1 in bit 0 if any sticky bit was set.
- R8: A source pulse in the same cycle as an acknowledge read of that source leaves the bit set.
- R9: A tx-abort pulse ORs `cause_in` into the cause word, which is read at address 3. Only bits 0-5, 7 and 9-11 are kept; bits 6 and 8 always read 0.
- R10: A read of address 11 (the tx-abort acknowledge) clears bit 6 and the whole cause word. A tx-abort pulse in the same cycle loads the fresh cause instead.
- R11: Writes to any address other than 2 change nothing. Reads of addresses 0-3 have no side effect. A read of an address above 16 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_in | input | NUM_SRC | Event pulses (sticky bits) and levels (bits 2, 4) |
| cause_in | input | NUM_SRC | Abort reason bits, sampled on a tx-abort pulse |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | NUM_SRC | Write data |
| rdata | output | NUM_SRC | Read data, valid while rd_en is high |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that:
- the pending read agrees with `irq_o`;
- a zero enable word holds the interrupt low;
- the level bits track their inputs;
- no sticky bit drops without an acknowledge;
- the abort acknowledge empties the cause word;
- reserved cause bits stay zero.

Only the bench scenarios can show the following:
- that every acknowledge address clears exactly its own source, across all twelve sources;
- that the pending word equals raw AND enable for each enable pattern;
- that a pulse coinciding with an acknowledge survives;
- that cause bits accumulate over several aborts;
- that stray writes and unmapped reads leave the state intact.

// File: rtl/irq_agg_pkg.sv
// Package: shared register addresses and source indices for the aggregator.
// Assumes a twelve-source layout; addresses are word indices.
package irq_agg_pkg;
    localparam int A_PENDING  = 0;
    localparam int A_RAW      = 1;
    localparam int A_ENABLE   = 2;
    localparam int A_CAUSE    = 3;
    localparam int A_ACK_ALL  = 4;
    localparam int A_ACK_BASE = 5;
    localparam int SRC_ABORT  = 6;
    localparam logic [11:0] LEVEL_DEFAULT = 12'h014;
    localparam logic [11:0] CAUSE_KEEP    = 12'hEBF;
endpackage

// File: rtl/irq_src_cell.sv
// One status bit. LEVEL=1: registered copy of the input, no acknowledge.
// LEVEL=0: set by a pulse, cleared by ack; set wins over ack.
module irq_src_cell #(
    parameter bit LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic ack,
    output logic q
);
    generate
        if (LEVEL) begin : g_level
            logic unused_ack;
            assign unused_ack = ack;
            // track the level input one cycle late
            always_ff @(posedge clk) begin
                if (!rst_n) q <= 1'b0;
                else        q <= evt;
            end
        end else begin : g_sticky
            // latch pulse, hold until acknowledged
            always_ff @(posedge clk) begin
                if (!rst_n) q <= 1'b0;
                else        q <= evt | (q & ~ack);
            end
        end
    endgenerate
endmodule

// File: rtl/irq_abort_cause.sv
// Abort reason word. Accumulates masked reasons on each abort pulse,
// cleared by ack; an abort in the ack cycle loads the new reason alone.
module irq_abort_cause #(
    parameter int          W    = 12,
    parameter logic [W-1:0] KEEP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic         ack,
    input  logic [W-1:0] cause_in,
    output logic [W-1:0] cause_q
);
    logic [W-1:0] base;
    // keep old content unless this cycle acknowledges it
    always_comb base = ack ? '0 : cause_q;

    // update the reason word
    always_ff @(posedge clk) begin
        if (!rst_n)       cause_q <= '0;
        else if (capture) cause_q <= base | (cause_in & KEEP);
        else              cause_q <= base;
    end
endmodule

// File: rtl/irq_reg_access.sv
// Address decode and read mux. Produces acknowledge strobes and the
// enable write strobe; read data is combinational while rd_en is high.
module irq_reg_access
    import irq_agg_pkg::*;
#(
    parameter int           N      = 12,
    parameter int           ADDR_W = 5,
    parameter logic [N-1:0] LEVEL  = '0
) (
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      raw,
    input  logic [N-1:0]      enable,
    input  logic [N-1:0]      cause,
    output logic [N-1:0]      ack_vec,
    output logic              ack_all,
    output logic              enable_we,
    output logic [N-1:0]      rdata
);
    localparam int LAST_ACK = A_ACK_BASE + N - 1;

    logic [ADDR_W-1:0] idx;
    logic              in_ack_range;

    // per-source acknowledge strobes
    for (genvar i = 0; i < N; i++) begin : g_ack
        assign ack_vec[i] = rd_en && (addr == ADDR_W'(A_ACK_BASE + i));
    end

    assign ack_all   = rd_en && (addr == ADDR_W'(A_ACK_ALL));
    assign enable_we = wr_en && (addr == ADDR_W'(A_ENABLE));

    // offset into the per-source acknowledge block
    always_comb begin
        idx          = addr - ADDR_W'(A_ACK_BASE);
        in_ack_range = (addr >= ADDR_W'(A_ACK_BASE)) && (addr <= ADDR_W'(LAST_ACK));
    end

    // read data selection
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == ADDR_W'(A_PENDING))      rdata = raw & enable;
            else if (addr == ADDR_W'(A_RAW))     rdata = raw;
            else if (addr == ADDR_W'(A_ENABLE))  rdata = enable;
            else if (addr == ADDR_W'(A_CAUSE))   rdata = cause;
            else if (addr == ADDR_W'(A_ACK_ALL)) rdata[0] = |(raw & ~LEVEL);
            else if (in_ack_range)               rdata[0] = raw[idx];
        end
    end
endmodule

// File: rtl/irq_aggregator.sv
// Top: twelve status cells, enable word, abort-cause word, register access
// and the interrupt OR. Assumes NUM_SRC fits the address map in ADDR_W.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int                 NUM_SRC   = 12,
    parameter int                 ADDR_W    = 5,
    parameter logic [NUM_SRC-1:0] LEVEL_SRC = LEVEL_DEFAULT,
    parameter logic [NUM_SRC-1:0] KEEP_MASK = CAUSE_KEEP
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [NUM_SRC-1:0] cause_in,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] rdata,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] raw_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] cause_q;
    logic [NUM_SRC-1:0] ack_vec;
    logic               ack_all;
    logic               enable_we;

    irq_reg_access #(.N(NUM_SRC), .ADDR_W(ADDR_W), .LEVEL(LEVEL_SRC)) u_access (
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .addr      (addr),
        .raw       (raw_q),
        .enable    (mask_q),
        .cause     (cause_q),
        .ack_vec   (ack_vec),
        .ack_all   (ack_all),
        .enable_we (enable_we),
        .rdata     (rdata)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        irq_src_cell #(.LEVEL(LEVEL_SRC[i])) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (src_in[i]),
            .ack   (ack_vec[i] | ack_all),
            .q     (raw_q[i])
        );
    end

    irq_abort_cause #(.W(NUM_SRC), .KEEP(KEEP_MASK)) u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (src_in[SRC_ABORT]),
        .ack      (ack_vec[SRC_ABORT] | ack_all),
        .cause_in (cause_in),
        .cause_q  (cause_q)
    );

    // enable word register
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '0;
        else if (enable_we) mask_q <= wdata;
    end

    // single interrupt line
    assign irq_o = |(raw_q & mask_q);
endmodule

// File: rtl/irq_aggregator_checker.sv
// Cycle-by-cycle properties of irq_aggregator, bound into the top.
module irq_aggregator_checker
    import irq_agg_pkg::*;
#(
    parameter int                 NUM_SRC   = 12,
    parameter int                 ADDR_W    = 5,
    parameter logic [NUM_SRC-1:0] LEVEL_SRC = LEVEL_DEFAULT
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_in,
    input logic               rd_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [NUM_SRC-1:0] rdata,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] raw_q,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [NUM_SRC-1:0] cause_q
);
    logic [NUM_SRC-1:0] ack_hit;
    logic               abort_ack;
    logic               ack_read;

    // which bits this cycle's read may clear
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++)
            ack_hit[i] = rd_en && ((addr == ADDR_W'(A_ACK_BASE + i)) || (addr == ADDR_W'(A_ACK_ALL)));
        abort_ack = ack_hit[SRC_ABORT];
        ack_read  = rd_en && (addr >= ADDR_W'(A_ACK_BASE)) && (addr < ADDR_W'(A_ACK_BASE + NUM_SRC));
    end

    // R5: the pending read and the interrupt line agree
    p_pending_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(A_PENDING)) |-> ((rdata != '0) == irq_o));

    // R5: enable word of zero silences the line
    p_mask_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_o);

    // R3: level bits follow the input one cycle late
    p_level_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_q & LEVEL_SRC) == ($past(src_in) & LEVEL_SRC)));

    // R2: a sticky bit only drops after an acknowledge read
    p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(raw_q) & ~LEVEL_SRC & ~$past(ack_hit)) & ~raw_q) == '0));

    // R10: abort acknowledge without a new abort empties the cause word
    p_cause_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_ack && !src_in[SRC_ABORT]) |=> (cause_q == '0 && !raw_q[SRC_ABORT]));

    // R9: reserved cause bits never set
    p_cause_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cause_q[6] && !cause_q[8]));

    // R6: acknowledge reads return at most bit 0
    p_ack_rdata_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_read |-> (rdata[NUM_SRC-1:1] == '0));
endmodule

bind irq_aggregator irq_aggregator_checker #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .LEVEL_SRC(LEVEL_SRC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_in  (src_in),
    .rd_en   (rd_en),
    .addr    (addr),
    .rdata   (rdata),
    .irq_o   (irq_o),
    .raw_q   (raw_q),
    .mask_q  (mask_q),
    .cause_q (cause_q)
);

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
    localparam int N = 12;
    localparam int AW = 5;
    localparam logic [N-1:0] LVL    = 12'h014;
    localparam logic [N-1:0] STICKY = ~LVL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_in = '0;
    logic [N-1:0]  cause_in = '0;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [N-1:0]  wdata = '0;
    logic [N-1:0]  rdata;
    logic          irq_o;

    int n_run = 0;
    int n_fail = 0;
    logic [N-1:0] lvl_hold = '0;

    irq_aggregator u_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .cause_in(cause_in),
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_o(irq_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // read with an optional same-cycle source pulse
    task automatic rd_evt(input int a, input logic [N-1:0] e, input logic [N-1:0] c,
                          output logic [N-1:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = AW'(a); src_in = e | lvl_hold; cause_in = c;
        #1 d = rdata;
        @(posedge clk);
        #1 rd_en = 1'b0; src_in = lvl_hold; cause_in = '0;
    endtask

    task automatic rd(input int a, output logic [N-1:0] d);
        rd_evt(a, '0, '0, d);
    endtask

    task automatic wr(input int a, input logic [N-1:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(a); wdata = v;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [N-1:0] e, input logic [N-1:0] c);
        @(negedge clk);
        src_in = e | lvl_hold; cause_in = c;
        @(posedge clk);
        #1 src_in = lvl_hold; cause_in = '0;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [N-1:0] d;
        logic [N-1:0] pat;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        rd(0, d); chk("R1 pending", d, '0);
        rd(1, d); chk("R1 raw", d, '0);
        rd(2, d); chk("R1 enable", d, '0);
        rd(3, d); chk("R1 cause", d, '0);
        @(negedge clk); chk("R1 irq", N'(irq_o), '0);

        // R2/R6: every acknowledge address against a full sticky set
        for (int j = 0; j < N; j++) begin
            pulse(STICKY, '0);
            rd(1, d); chk("R2 raw all sticky", d, STICKY);
            rd(5 + j, d); chk("R6 ack return", d, N'(STICKY[j]));
            rd(1, d); chk("R6 only own bit", d, STICKY & ~(N'(1) << j));
            rd(4, d); chk("R7 ack-all return", d, N'((STICKY & ~(N'(1) << j)) != '0));
            rd(1, d); chk("R7 raw cleared", d, '0);
        end
        rd(4, d); chk("R7 ack-all empty", d, '0);

        // R3: level bits follow input, ignore acknowledges
        lvl_hold = LVL; @(negedge clk); src_in = lvl_hold;
        repeat (2) @(posedge clk);
        rd(1, d); chk("R3 level on", d, LVL);
        rd(7, d); chk("R3 ack of level returns state", d, 12'h001);
        rd(9, d); rd(4, d);
        rd(1, d); chk("R3 level survives acks", d, LVL);
        lvl_hold = '0; @(negedge clk); src_in = '0;
        @(posedge clk);
        rd(1, d); chk("R3 level off", d, '0);

        // R4/R5: enable sweep over a fixed sticky pattern
        pat = 12'hA4B & STICKY;
        pulse(pat, '0);
        for (int m = 0; m <= N + 1; m++) begin
            logic [N-1:0] msk;
            msk = (m == 0) ? '0 : (m == N + 1) ? '1 : (N'(1) << (m - 1));
            wr(2, msk);
            rd(2, d); chk("R4 enable readback", d, msk);
            rd(0, d); chk("R4 pending", d, pat & msk);
            @(negedge clk); chk("R5 irq", N'(irq_o), N'((pat & msk) != '0));
        end
        wr(2, '0);
        @(negedge clk); chk("R5 zero enable silent", N'(irq_o), '0);
        rd(4, d);

        // R8: pulse coinciding with its own ack and with ack-all
        pulse(12'h008, '0);
        rd_evt(8, 12'h008, '0, d); chk("R8 ack return", d, 12'h001);
        rd(1, d); chk("R8 bit kept", d, 12'h008);
        rd_evt(4, 12'h001, '0, d);
        rd(1, d); chk("R8 ack-all keeps new", d, 12'h001);
        rd(4, d);

        // R9: cause capture, filtering and accumulation
        pulse(12'h040, 12'hFFF);
        rd(3, d); chk("R9 cause filtered", d, 12'hEBF);
        rd(11, d); chk("R10 abort ack return", d, 12'h001);
        rd(3, d); chk("R10 cause wiped", d, '0);
        rd(1, d); chk("R10 abort bit cleared", d, '0);
        pulse(12'h040, 12'h008);
        pulse(12'h040, 12'h001);
        rd(3, d); chk("R9 cause accumulates", d, 12'h009);
        rd_evt(11, 12'h040, 12'h002, d);
        rd(3, d); chk("R10 fresh cause on same cycle", d, 12'h002);
        rd(1, d); chk("R10 abort bit kept", d, 12'h040);
        rd(4, d);
        rd(3, d); chk("R7 ack-all wipes cause", d, '0);

        // R11: stray writes, side-effect-free reads, unmapped reads
        pulse(12'h201, '0);
        wr(1, '0); wr(0, '0); wr(3, '0); wr(6, '0); wr(4, '0);
        rd(1, d); chk("R11 writes ignored", d, 12'h201);
        rd(2, d); chk("R11 enable untouched", d, '0);
        rd(0, d); rd(1, d); rd(3, d);
        rd(1, d); chk("R11 status reads no effect", d, 12'h201);
        rd(20, d); chk("R11 unmapped zero", d, '0);
        rd(1, d); chk("R11 unmapped no effect", d, 12'h201);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule